// File: doc/BRIEF.md
# Streaming Parallel Sorting Network

This block sorts a vector of `CHAN_NUM` unsigned or two's-complement values in a single stream transfer. It sits behind an AXI4-Stream slave port and an AXI4-Stream master port. Each accepted input beat carries one packed vector. Each output beat carries the same values rearranged into ascending or descending order. Inside is a bitonic compare-exchange network of `log2(CHAN_NUM)*(log2(CHAN_NUM)+1)/2` layers. A register can sit after every `PIPE_EVERY`-th layer, so the designer trades latency against clock speed.

A valid flag and a last flag travel alongside the vector in a short shift pipeline. That pipeline has one slot per registered layer. The network and the side pipeline share one advance enable. When the master side is blocked and the output slot is occupied, the whole pipeline freezes and the slave side stops accepting. With `PIPE_EVERY` set to zero, or set larger than the layer count, the block is a purely combinational sorter and the handshake signals pass straight through.

Top module: `axisBitonicSorter`

## Requirements
- R1: While `aresetn` is low at a rising `aclk` edge, every pipeline valid flag clears, and `m_axis_tvalid` is low in the cycle that follows.
- R2: Channel c of a vector occupies bits `[c*DATA_WIDTH +: DATA_WIDTH]`, so channel 0 is the least significant slice. With `DESCEND=0`, output channel 0 holds the smallest value and each higher channel holds a value no smaller than the channel below it.
- R3: `SIGNED_CMP=1` compares lanes as two's-complement numbers, so a lane with its top bit set ranks below zero. `SIGNED_CMP=0` compares lanes as unsigned numbers.
- R4: `DESCEND=1` reverses the order, so output channel 0 holds the largest value.
- R5: A beat transfers only on an edge where valid and ready are both high. Every accepted input vector leaves exactly once, and output beats keep input order.
- R6: The last flag of an input beat appears on the output beat that carries the sorted form of that same vector.
- R7: While `m_axis_tvalid` is high and `m_axis_tready` is low, the next cycle still shows the same `m_axis_tdata` and `m_axis_tlast`, with `m_axis_tvalid` high.
- R8: In a registered configuration, `s_axis_tready` is high exactly when `m_axis_tready` is high or `m_axis_tvalid` is low.
- R9: The latency equals the number of registered layers, `floor(layers/PIPE_EVERY)`. With the defaults (8 channels, 6 layers, `PIPE_EVERY=1`), a beat accepted at one edge is first presented as valid six edges later.
- R10: With input valid and output ready held high, one beat is accepted on every edge. Once the pipeline has filled, one sorted beat leaves on every edge.
- R11: With `PIPE_EVERY=0`, the path is combinational. In that case `m_axis_tvalid` follows `s_axis_tvalid`, `s_axis_tready` follows `m_axis_tready`, and `m_axis_tlast` follows `s_axis_tlast` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock, rising edge active |
| aresetn | input | 1 | Synchronous reset, active low |
| s_axis_tdata | input | DATA_WIDTH*CHAN_NUM | Unsorted input vector, channel 0 in the low slice |
| s_axis_tvalid | input | 1 | Input beat present |
| s_axis_tready | output | 1 | Block can take an input beat |
| s_axis_tlast | input | 1 | Packet-end flag of the input beat |
| m_axis_tdata | output | DATA_WIDTH*CHAN_NUM | Sorted output vector |
| m_axis_tvalid | output | 1 | Output beat present |
| m_axis_tready | input | 1 | Downstream can take the output beat |
| m_axis_tlast | output | 1 | Packet-end flag travelling with the output beat |

## Verification
Two things can happen on the same edge: a new vector enters at the slave port, and the output slot is held or released by downstream backpressure. A full pipeline under a blocked master must stop accepting input, while a blocked but partly empty pipeline must keep absorbing beats. The bench provokes both cases with independent random valid and ready patterns, together with a stretch of sustained traffic and a reset applied while the pipeline is full. A scoreboard is filled from the inputs the bench accepts and holds a reference sort of each vector with its last flag. It compares each output transfer against that scoreboard, so any loss, duplicate, reorder, missorted lane or misplaced last flag is reported, and any change of a stalled output is also reported.

// File: rtl/sortPkg.sv
package sortPkg;

  // Strobes from the flow control to the sorting datapath.
  typedef struct packed {
    logic advance;   // every pipeline register loads on this edge
  } flowCtrl_t;

  // Number of compare-exchange layers for 2**lg lanes.
  function automatic int netDepth(input int lg);
    return lg * (lg + 1) / 2;
  endfunction

  // Merge phase (0-based) a flattened layer index belongs to.
  function automatic int stageMerge(input int s);
    int p;
    p = 0;
    for (int t = 0; t < 32; t++)
      if ((t + 1) * (t + 2) / 2 <= s) p = t + 1;
    return p;
  endfunction

  // log2 of the compare distance used by a flattened layer index.
  function automatic int stageSpan(input int s);
    int p;
    p = stageMerge(s);
    return p - (s - p * (p + 1) / 2);
  endfunction

  // Layer s is followed by a register when (s+1) is a multiple of every.
  function automatic bit isRegStage(input int s, input int every);
    return (every > 0) && (((s + 1) % every) == 0);
  endfunction

  function automatic int regCount(input int depth, input int every);
    return (every > 0) ? depth / every : 0;
  endfunction

endpackage

// File: rtl/sortNetDatapath.sv
module sortNetDatapath
  import sortPkg::*;
#(
  parameter int DATA_WIDTH = 8,
  parameter int CHAN_NUM   = 8,
  parameter bit DESCEND    = 1'b0,
  parameter bit SIGNED_CMP = 1'b0,
  parameter int PIPE_EVERY = 1
) (
  input  logic                           clk,
  input  flowCtrl_t                      ctrl,
  input  logic [DATA_WIDTH*CHAN_NUM-1:0] inVec,
  output logic [DATA_WIDTH*CHAN_NUM-1:0] outVec
);

  localparam int LOG_CH = $clog2(CHAN_NUM);
  localparam int DEPTH  = netDepth(LOG_CH);
  localparam int VEC_W  = DATA_WIDTH * CHAN_NUM;

  function automatic logic above(input logic [DATA_WIDTH-1:0] a,
                                 input logic [DATA_WIDTH-1:0] b);
    if (SIGNED_CMP) return $signed(a) > $signed(b);
    else            return a > b;
  endfunction

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    localparam int MERGE = stageMerge(s);
    localparam int SPAN  = stageSpan(s);
    localparam int BLOCK = 2 << MERGE;
    localparam int DIST  = 1 << SPAN;

    logic [VEC_W-1:0] stageIn;
    logic [VEC_W-1:0] swapped;
    logic [VEC_W-1:0] stageOut;

    if (s == 0) begin : g_first
      assign stageIn = inVec;
    end else begin : g_next
      assign stageIn = g_stage[s-1].stageOut;
    end

    // One layer of compare-exchange cells; lane i pairs with lane i+DIST.
    always_comb begin
      logic [DATA_WIDTH-1:0] lo;
      logic [DATA_WIDTH-1:0] hi;
      logic                  up;
      swapped = stageIn;
      for (int i = 0; i < CHAN_NUM; i++) begin
        if ((i & DIST) == 0) begin
          lo = stageIn[i*DATA_WIDTH +: DATA_WIDTH];
          hi = stageIn[(i+DIST)*DATA_WIDTH +: DATA_WIDTH];
          up = (((i & BLOCK) == 0) ? 1'b1 : 1'b0) ^ DESCEND;
          if (above(lo, hi) == up) begin
            swapped[i*DATA_WIDTH +: DATA_WIDTH]        = hi;
            swapped[(i+DIST)*DATA_WIDTH +: DATA_WIDTH] = lo;
          end
        end
      end
    end

    if (isRegStage(s, PIPE_EVERY)) begin : g_reg
      always_ff @(posedge clk)
        if (ctrl.advance) stageOut <= swapped;
    end else begin : g_wire
      assign stageOut = swapped;
    end
  end

  assign outVec = g_stage[DEPTH-1].stageOut;

endmodule

// File: rtl/sortFlowCtrl.sv
module sortFlowCtrl
  import sortPkg::*;
#(
  parameter int NREG = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sValid,
  input  logic      sLast,
  output logic      sReady,
  output logic      mValid,
  output logic      mLast,
  input  logic      mReady,
  output flowCtrl_t ctrl
);

  if (NREG == 0) begin : g_comb
    assign sReady       = mReady;
    assign mValid       = sValid;
    assign mLast        = sLast;
    assign ctrl.advance = mReady;
  end else begin : g_piped
    localparam int CW = $clog2(NREG + 1) + 1;

    logic [NREG-1:0] vldPipe;
    logic [NREG-1:0] lastPipe;
    logic            advance;

    assign advance      = mReady || !vldPipe[NREG-1];
    assign ctrl.advance = advance;
    assign sReady       = advance;
    assign mValid       = vldPipe[NREG-1];
    assign mLast        = lastPipe[NREG-1];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vldPipe <= '0;
      end else if (advance) begin
        vldPipe[0] <= sValid;
        for (int i = 1; i < NREG; i++) vldPipe[i] <= vldPipe[i-1];
      end
    end

    always_ff @(posedge clk) begin
      if (advance) begin
        lastPipe[0] <= sLast;
        for (int i = 1; i < NREG; i++) lastPipe[i] <= lastPipe[i-1];
      end
    end

    // Checker state: beats taken in minus beats sent out.
    logic [CW-1:0] inFlight;
    always_ff @(posedge clk) begin
      if (!rstN) inFlight <= '0;
      else inFlight <= inFlight + CW'(sValid && sReady) - CW'(mValid && mReady);
    end

    assert_occupancy_R5: assert property (@(posedge clk) disable iff (!rstN)
      int'(inFlight) == $countones(vldPipe));

    assert_reset_R1: assert property (@(posedge clk)
      !rstN |=> !mValid);
  end

endmodule

// File: rtl/axisBitonicSorter.sv
module axisBitonicSorter
  import sortPkg::*;
#(
  parameter int DATA_WIDTH = 8,
  parameter int CHAN_NUM   = 8,
  parameter bit DESCEND    = 1'b0,
  parameter bit SIGNED_CMP = 1'b0,
  parameter int PIPE_EVERY = 1
) (
  input  logic                           aclk,
  input  logic                           aresetn,
  input  logic [DATA_WIDTH*CHAN_NUM-1:0] s_axis_tdata,
  input  logic                           s_axis_tvalid,
  output logic                           s_axis_tready,
  input  logic                           s_axis_tlast,
  output logic [DATA_WIDTH*CHAN_NUM-1:0] m_axis_tdata,
  output logic                           m_axis_tvalid,
  input  logic                           m_axis_tready,
  output logic                           m_axis_tlast
);

  localparam int LOG_CH = $clog2(CHAN_NUM);
  localparam int DEPTH  = netDepth(LOG_CH);
  localparam int NREG   = regCount(DEPTH, PIPE_EVERY);
  localparam int VEC_W  = DATA_WIDTH * CHAN_NUM;

  flowCtrl_t ctrl;

  sortFlowCtrl #(.NREG(NREG)) i_ctrl (
    .clk    (aclk),
    .rstN   (aresetn),
    .sValid (s_axis_tvalid),
    .sLast  (s_axis_tlast),
    .sReady (s_axis_tready),
    .mValid (m_axis_tvalid),
    .mLast  (m_axis_tlast),
    .mReady (m_axis_tready),
    .ctrl   (ctrl)
  );

  sortNetDatapath #(
    .DATA_WIDTH (DATA_WIDTH),
    .CHAN_NUM   (CHAN_NUM),
    .DESCEND    (DESCEND),
    .SIGNED_CMP (SIGNED_CMP),
    .PIPE_EVERY (PIPE_EVERY)
  ) i_data (
    .clk    (aclk),
    .ctrl   (ctrl),
    .inVec  (s_axis_tdata),
    .outVec (m_axis_tdata)
  );

  function automatic logic vecOrdered(input logic [VEC_W-1:0] v);
    logic ok;
    logic [DATA_WIDTH-1:0] a;
    logic [DATA_WIDTH-1:0] b;
    logic aGtB;
    logic bGtA;
    ok = 1'b1;
    for (int c = 0; c < CHAN_NUM - 1; c++) begin
      a = v[c*DATA_WIDTH +: DATA_WIDTH];
      b = v[(c+1)*DATA_WIDTH +: DATA_WIDTH];
      aGtB = SIGNED_CMP ? ($signed(a) > $signed(b)) : (a > b);
      bGtA = SIGNED_CMP ? ($signed(b) > $signed(a)) : (b > a);
      if (DESCEND ? bGtA : aGtB) ok = 1'b0;
    end
    return ok;
  endfunction

  // Lane order of every presented beat (R3 and R4 pick the comparison).
  assert_sorted_R2: assert property (@(posedge aclk) disable iff (!aresetn)
    m_axis_tvalid |-> vecOrdered(m_axis_tdata));

  if (NREG > 0) begin : g_holdChk
    assert_hold_R7: assert property (@(posedge aclk) disable iff (!aresetn)
      (m_axis_tvalid && !m_axis_tready) |=>
        (m_axis_tvalid && $stable(m_axis_tdata) && $stable(m_axis_tlast)));
  end

endmodule

// File: tb/test_axisBitonicSorter.sv
`timescale 1ns/1ps
module test_axisBitonicSorter;

  localparam int DW  = 8;
  localparam int CH  = 8;
  localparam int W   = DW * CH;
  localparam int LAT = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rstN = 1'b0;
  logic [W-1:0] sData = '0;
  logic         sValid = 1'b0;
  logic         sLast = 1'b0;
  logic         sReady;
  logic [W-1:0] mData;
  logic         mValid;
  logic         mReady = 1'b0;
  logic         mLast;

  logic [W-1:0] altData = '0;
  logic         altValid = 1'b0;
  logic         altLast = 1'b0;
  logic         altSReady;
  logic [W-1:0] altMData;
  logic         altMValid;
  logic         altMReady = 1'b0;
  logic         altMLast;

  axisBitonicSorter #(.DATA_WIDTH(DW), .CHAN_NUM(CH)) i_axisBitonicSorter (
    .aclk(clk), .aresetn(rstN),
    .s_axis_tdata(sData), .s_axis_tvalid(sValid), .s_axis_tready(sReady), .s_axis_tlast(sLast),
    .m_axis_tdata(mData), .m_axis_tvalid(mValid), .m_axis_tready(mReady), .m_axis_tlast(mLast));

  axisBitonicSorter #(.DATA_WIDTH(DW), .CHAN_NUM(CH), .DESCEND(1'b1), .SIGNED_CMP(1'b1),
                      .PIPE_EVERY(0)) i_axisBitonicSorter_alt (
    .aclk(clk), .aresetn(rstN),
    .s_axis_tdata(altData), .s_axis_tvalid(altValid), .s_axis_tready(altSReady), .s_axis_tlast(altLast),
    .m_axis_tdata(altMData), .m_axis_tvalid(altMValid), .m_axis_tready(altMReady), .m_axis_tlast(altMLast));

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [W-1:0] expD[$];
  logic         expL[$];

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] sortRef(input logic [W-1:0] v, input bit sgn, input bit desc);
    int k[CH];
    int t;
    logic [W-1:0] r;
    for (int c = 0; c < CH; c++)
      k[c] = sgn ? int'($signed(v[c*DW +: DW])) : int'(v[c*DW +: DW]);
    for (int a = 0; a < CH; a++)
      for (int b = 0; b < CH - 1 - a; b++)
        if (k[b] > k[b+1]) begin t = k[b]; k[b] = k[b+1]; k[b+1] = t; end
    for (int c = 0; c < CH; c++)
      r[c*DW +: DW] = DW'(desc ? k[CH-1-c] : k[c]);
    return r;
  endfunction

  // Driver: one cycle of stimulus; records accepted beats in the scoreboard.
  task automatic driveCycle(input bit v, input logic [W-1:0] d, input bit l, input bit r);
    @(negedge clk);
    sValid = v; sData = d; sLast = l; mReady = r;
    #1;
    if (rstN) begin
      check(sReady == (mReady || !mValid), "R8 ready rule", W'(sReady), W'(mReady || !mValid));
      if (sValid && sReady) begin
        expD.push_back(sortRef(sData, 1'b0, 1'b0));
        expL.push_back(sLast);
      end
    end
  endtask

  // Monitor: compares each output transfer and checks stall stability.
  logic         prevStall = 1'b0;
  logic [W-1:0] prevD = '0;
  logic         prevL = 1'b0;
  always @(negedge clk) begin
    #1;
    if (!rstN) begin
      prevStall = 1'b0;
    end else begin
      if (prevStall) begin
        check(mValid == 1'b1, "R7 valid held", W'(mValid), W'(1));
        check(mData == prevD && mLast == prevL, "R7 data held", mData, prevD);
      end
      if (mValid && mReady) begin
        if (expD.size() == 0) begin
          check(1'b0, "R5 unexpected beat", mData, '0);
        end else begin
          logic [W-1:0] ed;
          logic el;
          ed = expD.pop_front();
          el = expL.pop_front();
          check(mData == ed, "R2 sorted data", mData, ed);
          check(mLast == el, "R6 last aligned", W'(mLast), W'(el));
        end
      end
      prevStall = mValid && !mReady;
      prevD = mData;
      prevL = mLast;
    end
  end

  task automatic altCheck(input logic [W-1:0] d, input bit v, input bit l, input bit r);
    @(negedge clk);
    altData = d; altValid = v; altLast = l; altMReady = r;
    #1;
    check(altMValid == v, "R11 valid passes", W'(altMValid), W'(v));
    check(altSReady == r, "R11 ready passes", W'(altSReady), W'(r));
    check(altMLast == l, "R11 last passes", W'(altMLast), W'(l));
    check(altMData == sortRef(d, 1'b1, 1'b1), "R3 R4 signed descending", altMData, sortRef(d, 1'b1, 1'b1));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seen;
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check(mValid == 1'b0, "R1 valid low in reset", W'(mValid), W'(0));
    @(negedge clk);
    rstN = 1'b1;

    // R9: latency of a lone beat
    driveCycle(1'b1, 64'h0102_0304_0506_0708, 1'b1, 1'b1);
    seen = 0;
    for (int n = 1; n <= 20; n++) begin
      driveCycle(1'b0, '0, 1'b0, 1'b1);
      if (mValid && seen == 0) seen = n;
    end
    check(seen == LAT, "R9 latency", W'(seen), W'(LAT));

    // R2 R3: directed patterns (unsigned ascending on the main instance)
    driveCycle(1'b1, 64'h80_7F_00_FF_01_FE_40_C0, 1'b0, 1'b1);
    driveCycle(1'b1, 64'h55_55_55_55_55_55_55_55, 1'b1, 1'b1);
    driveCycle(1'b1, 64'h00_11_22_33_44_55_66_77, 1'b0, 1'b1);
    driveCycle(1'b1, 64'hFF_00_FF_00_FF_00_FF_00, 1'b1, 1'b1);
    driveCycle(1'b1, 64'h77_66_55_44_33_22_11_00, 1'b0, 1'b1);

    // R5 R6 R7 R8: random valid and ready patterns
    for (int n = 0; n < 800; n++)
      driveCycle(($urandom % 4) != 0, {$urandom, $urandom}, $urandom % 2, ($urandom % 3) != 0);

    // R10: sustained traffic
    for (int n = 0; n < 40; n++) begin
      driveCycle(1'b1, {$urandom, $urandom}, $urandom % 2, 1'b1);
      check(sReady == 1'b1, "R10 accept every edge", W'(sReady), W'(1));
      if (n >= LAT) check(mValid == 1'b1, "R10 emit every edge", W'(mValid), W'(1));
    end

    // R5: drain, nothing lost
    for (int n = 0; n < 20; n++) driveCycle(1'b0, '0, 1'b0, 1'b1);
    check(expD.size() == 0, "R5 all beats delivered", W'(expD.size()), W'(0));
    check(mValid == 1'b0, "R5 no extra beat", W'(mValid), W'(0));

    // R1 R8: fill under backpressure, then reset
    for (int n = 0; n < 10; n++) driveCycle(1'b1, {$urandom, $urandom}, 1'b1, 1'b0);
    check(sReady == 1'b0, "R8 full pipeline blocks input", W'(sReady), W'(0));
    @(negedge clk);
    rstN = 1'b0; sValid = 1'b0;
    expD.delete();
    expL.delete();
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(mValid == 1'b0, "R1 flushed by reset", W'(mValid), W'(0));
    for (int n = 0; n < 10; n++) begin
      driveCycle(1'b0, '0, 1'b0, 1'b1);
      check(mValid == 1'b0, "R1 no stale beat", W'(mValid), W'(0));
    end

    // R3 R4 R11: combinational signed descending instance
    altCheck(64'h80_7F_00_FF_01_FE_40_C0, 1'b1, 1'b1, 1'b1);
    altCheck(64'h01_02_03_04_FC_FD_FE_FF, 1'b0, 1'b0, 1'b1);
    altCheck(64'h7F_7F_80_80_00_00_FF_FF, 1'b1, 1'b0, 1'b0);
    altCheck({$urandom, $urandom}, 1'b1, 1'b1, 1'b0);
    check(sortRef(64'h80_7F_00_FF_01_FE_40_C0, 1'b1, 1'b1) == 64'h80_C0_FE_FF_00_01_40_7F,
          "R3 reference sanity", sortRef(64'h80_7F_00_FF_01_FE_40_C0, 1'b1, 1'b1), 64'h80_C0_FE_FF_00_01_40_7F);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule